// File: doc/BRIEF.md
# Video memory cycle allocator

This block generates a programmable raster timing pattern and decides, on every clock (one memory cycle), which of three clients may use the shared frame-buffer memory: the display reader, DRAM refresh, or command execution. Each scan line has four horizontal segments in this order: blanking, front porch, the active window and back porch. Each field has four vertical segments in this order: front porch, active lines, back porch and blanking. Every segment length is an input.

Memory cycles are shared out by scan position. In normal mode the display reader takes the whole active window of every active line. In video-RAM mode the display reader takes only the first window cycle of each active line, and a load strobe for the video-RAM shift register is raised at the end of horizontal blanking. One of every nine non-visible lines carries a refresh burst in the window columns. Command execution takes every other cycle. The length inputs are copied into shadow registers when vertical blanking begins, so a new raster takes effect at a field boundary.

Top module: `scan_mem_allocator`

## Requirements
- R1: `grant` is one-hot on every cycle: bit 0 is display, bit 1 is refresh and bit 2 is command.
- R2: A line runs for `hb_len`, `hf_len`, `ha_len` and `hk_len` cycles in the order blanking, front porch, window, back porch. A field runs for `vf_len`, `va_len`, `vk_len` and `vb_len` lines in the order front porch, active, back porch, blanking. `hblank` is high only in horizontal blanking and `vblank` only in vertical blanking. `col` is the cycle index within the window and `line` is the line index within the active lines; both are 0 elsewhere.
- R3: With `vram_mode`=0 and `disp_off`=0, every window cycle of every active line is granted to the display.
- R4: With `disp_off`=1, no cycle is granted to the display, and window cycles on active lines go to command.
- R5: With `vram_mode`=1 and `disp_off`=0, only the window cycle with `col`=0 on each active line goes to the display. The other cycles of that line go to command.
- R6: A modulo-9 counter advances at the end of every non-visible line (every line outside the active lines) and keeps running across fields. On the non-visible lines where it reads 0, the window columns are granted to refresh.
- R7: With `refr_off`=1, no cycle is granted to refresh.
- R8: With `vram_mode`=1 and `disp_off`=0, `sr_load` pulses on the last horizontal-blanking cycle of each active line. It is low at all other times.
- R9: Reset puts the block at the first horizontal-blanking cycle of the first front-porch line. Every cycle of that first line is granted to command, and the refresh counter starts at 0 on the next line.
- R10: The length inputs take effect only when the raster enters vertical blanking (and once just after reset). A change made earlier in a field does not disturb the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_len | input | LW | Horizontal blanking length in cycles |
| hf_len | input | LW | Horizontal front porch length |
| ha_len | input | LW | Active window width |
| hk_len | input | LW | Horizontal back porch length |
| vf_len | input | LW | Vertical front porch length in lines |
| va_len | input | LW | Active line count |
| vk_len | input | LW | Vertical back porch length |
| vb_len | input | LW | Vertical blanking length |
| vram_mode | input | 1 | Video-RAM mode: one display cycle per line |
| disp_off | input | 1 | Disables the display process |
| refr_off | input | 1 | Disables the refresh process |
| hblank | output | 1 | High during horizontal blanking |
| vblank | output | 1 | High during vertical blanking |
| grant | output | 3 | One-hot owner of the cycle: {command, refresh, display} |
| col | output | LW | Column within the active window |
| line | output | LW | Line within the active lines |
| sr_load | output | 1 | Shift-register load strobe |

## Verification
The hardest case to reach is a timing change that arrives partway through a field. It must be held back until vertical blanking, and the refresh counter must stay in step across the switch even though the number of non-visible lines per field changes. The stimulus alters every length input during an active line. It then runs several fields while a bench-side raster model adopts the new lengths only at its own entry to vertical blanking. It also reaches the ninth-line refresh in fields other than the first, which shows the counter running across field boundaries.

// File: rtl/scan_mem_allocator.sv
module scan_mem_allocator #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] hb_len,
  input  logic [LW-1:0] hf_len,
  input  logic [LW-1:0] ha_len,
  input  logic [LW-1:0] hk_len,
  input  logic [LW-1:0] vf_len,
  input  logic [LW-1:0] va_len,
  input  logic [LW-1:0] vk_len,
  input  logic [LW-1:0] vb_len,
  input  logic          vram_mode,
  input  logic          disp_off,
  input  logic          refr_off,
  output logic          hblank,
  output logic          vblank,
  output logic [2:0]    grant,
  output logic [LW-1:0] col,
  output logic [LW-1:0] line,
  output logic          sr_load
);
  localparam logic [1:0] H_BLANK = 2'd0, H_WIN = 2'd2, H_BACK = 2'd3;
  localparam logic [1:0] V_ACT = 2'd1, V_BACK = 2'd2, V_BLANK = 2'd3;
  localparam logic [2:0] G_DISP = 3'b001, G_REF = 3'b010, G_CMD = 3'b100;

  logic [3:0][LW-1:0] h_sh, v_sh, h_in, v_in, h_use, v_use;
  logic [1:0]    hph, vph;
  logic [LW-1:0] hcnt, vcnt;
  logic [3:0]    nv;
  logic          armed, primed;
  logic          hend, line_end, vend, in_win, act_line;

  assign h_in  = {hk_len, ha_len, hf_len, hb_len};
  assign v_in  = {vb_len, vk_len, va_len, vf_len};
  assign h_use = primed ? h_sh : h_in;
  assign v_use = primed ? v_sh : v_in;

  assign hend     = ({1'b0, hcnt} + 1'b1) >= {1'b0, h_use[hph]};
  assign line_end = hend && (hph == H_BACK);
  assign vend     = line_end && (({1'b0, vcnt} + 1'b1) >= {1'b0, v_use[vph]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hph    <= H_BLANK;
      hcnt   <= '0;
      vph    <= 2'd0;
      vcnt   <= '0;
      nv     <= '0;
      armed  <= 1'b0;
      primed <= 1'b0;
      h_sh   <= '0;
      v_sh   <= '0;
    end else begin
      if (hend) begin
        hph  <= hph + 2'd1;
        hcnt <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (line_end) begin
        armed <= 1'b1;
        if (armed && vph != V_ACT) nv <= (nv == 4'd8) ? 4'd0 : nv + 4'd1;
        if (vend) begin
          vph  <= vph + 2'd1;
          vcnt <= '0;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end
      if (!primed || (vend && vph == V_BACK)) begin
        h_sh   <= h_in;
        v_sh   <= v_in;
        primed <= 1'b1;
      end
    end
  end

  assign in_win   = hph == H_WIN;
  assign act_line = vph == V_ACT;
  assign hblank   = hph == H_BLANK;
  assign vblank   = vph == V_BLANK;
  assign col      = in_win ? hcnt : '0;
  assign line     = act_line ? vcnt : '0;
  assign sr_load  = armed && vram_mode && !disp_off && act_line && hblank && hend;

  always_comb begin
    grant = G_CMD;
    if (armed && in_win) begin
      if (act_line) begin
        if (!disp_off && (!vram_mode || hcnt == '0)) grant = G_DISP;
      end else if (!refr_off && nv == 4'd0) begin
        grant = G_REF;
      end
    end
  end
endmodule

// File: rtl/scan_mem_allocator_chk.sv
module scan_mem_allocator_chk #(
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vram_mode,
  input logic          disp_off,
  input logic          refr_off,
  input logic          hblank,
  input logic [2:0]    grant,
  input logic [LW-1:0] col,
  input logic          sr_load
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R1
  AST_BLANK_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    hblank |-> grant == 3'b100); // R2
  AST_DISP_OFF_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> !grant[0]); // R4
  AST_VRAM_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_mode && grant[0]) |-> col == '0); // R5
  AST_REFR_OFF_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    refr_off |-> !grant[1]); // R7
  AST_LOAD_IN_HBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |-> (hblank && vram_mode && !disp_off)); // R8
  AST_LOAD_THEN_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_load |=> !hblank); // R8
endmodule

bind scan_mem_allocator scan_mem_allocator_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vram_mode(vram_mode), .disp_off(disp_off),
  .refr_off(refr_off), .hblank(hblank), .grant(grant), .col(col), .sr_load(sr_load)
);

// File: tb/tb_scan_mem_allocator.sv
`timescale 1ns/1ps
module tb_scan_mem_allocator;
  localparam int LW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [LW-1:0] hb_len, hf_len, ha_len, hk_len, vf_len, va_len, vk_len, vb_len;
  logic vram_mode = 1'b0, disp_off = 1'b0, refr_off = 1'b0;
  logic hblank, vblank, sr_load;
  logic [2:0] grant;
  logic [LW-1:0] col, line;

  always #2.5 clk = ~clk;

  scan_mem_allocator #(.LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .hb_len(hb_len), .hf_len(hf_len), .ha_len(ha_len),
    .hk_len(hk_len), .vf_len(vf_len), .va_len(va_len), .vk_len(vk_len), .vb_len(vb_len),
    .vram_mode(vram_mode), .disp_off(disp_off), .refr_off(refr_off),
    .hblank(hblank), .vblank(vblank), .grant(grant), .col(col), .line(line),
    .sr_load(sr_load)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mhb, mhf, mha, mhk, mvf, mva, mvk, mvb;
  int x, fl, lines, nvc, cyc;

  task automatic chk(input string req, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] cycle %0d x=%0d fl=%0d: got %0d expected %0d",
               req, ctx, cyc, x, fl, act, exp);
    end
  endtask

  task automatic set_cfg(input int a, b, c, d, e, f, g, h);
    hb_len = LW'(a); hf_len = LW'(b); ha_len = LW'(c); hk_len = LW'(d);
    vf_len = LW'(e); va_len = LW'(f); vk_len = LW'(g); vb_len = LW'(h);
  endtask

  task automatic model_load();
    mhb = int'(hb_len); mhf = int'(hf_len); mha = int'(ha_len); mhk = int'(hk_len);
    mvf = int'(vf_len); mva = int'(va_len); mvk = int'(vk_len); mvb = int'(vb_len);
  endtask

  task automatic compare(input string ctx);
    bit win, act, armed;
    int ecol, eline, eg;
    string greq;
    win   = (x >= mhb + mhf) && (x < mhb + mhf + mha);
    act   = (fl >= mvf) && (fl < mvf + mva);
    armed = lines >= 1;
    ecol  = win ? x - mhb - mhf : 0;
    eline = act ? fl - mvf : 0;
    eg = 4; greq = "R1";
    if (!armed) greq = "R9";
    else if (act && win && disp_off) greq = "R4";
    else if (!act && win && nvc == 0 && refr_off) greq = "R7";
    if (armed && act && win && !disp_off && (!vram_mode || ecol == 0)) begin
      eg = 1; greq = vram_mode ? "R5" : "R3";
    end else if (armed && act && win && vram_mode && !disp_off) begin
      greq = "R5";
    end else if (armed && !act && win && !refr_off && nvc == 0) begin
      eg = 2; greq = "R6";
    end
    chk(greq, ctx, int'(grant), eg);
    chk("R2", ctx, int'(hblank), int'(x < mhb));
    chk("R2", ctx, int'(vblank), int'(fl >= mvf + mva + mvk));
    chk("R2", ctx, int'(col), ecol);
    chk("R2", ctx, int'(line), eline);
    chk("R8", ctx, int'(sr_load),
        int'(armed && vram_mode && !disp_off && act && x == mhb - 1));
  endtask

  task automatic advance();
    bit act;
    cyc++;
    x++;
    if (x == mhb + mhf + mha + mhk) begin
      x = 0;
      act = (fl >= mvf) && (fl < mvf + mva);
      if (lines >= 1 && !act) nvc = (nvc + 1) % 9;
      lines++;
      fl++;
      if (fl == mvf + mva + mvk) begin
        model_load();          // R10: new lengths adopted at vertical blanking entry
        fl = mvf + mva + mvk;
      end else if (fl >= mvf + mva + mvk + mvb) begin
        fl = 0;
      end
    end
  endtask

  task automatic run(input int n, input string ctx);
    for (int i = 0; i < n; i++) begin
      compare(ctx);
      advance();
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    set_cfg(3, 2, 4, 2, 2, 3, 1, 2);
    vram_mode = 0; disp_off = 0; refr_off = 0;
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9", "in reset", int'(grant), 4);
    chk("R9", "in reset", int'(hblank), 1);
    chk("R9", "in reset", int'(vblank), 0);
    chk("R9", "in reset", int'(col), 0);
    chk("R9", "in reset", int'(line), 0);
    rst_n = 1;
    model_load();
    x = 0; fl = 0; lines = 0; nvc = 0; cyc = 0;
    run(11, "R9 first line");
    run(88 * 2, "R9 after reset");
  endtask

  task automatic t_full_display();
    run(88 * 3, "R3 normal display, R6 refresh across fields");
  endtask

  task automatic t_disp_off();
    disp_off = 1;
    run(88 * 2, "R4 display disabled");
    disp_off = 0;
  endtask

  task automatic t_vram();
    vram_mode = 1;
    run(88 * 2, "R5 R8 video-RAM mode");
    disp_off = 1;
    run(88, "R8 video-RAM with display off");
    disp_off = 0;
    vram_mode = 0;
  endtask

  task automatic t_refr_off();
    refr_off = 1;
    run(88 * 2, "R7 refresh disabled");
    refr_off = 0;
  endtask

  task automatic t_cfg_change();
    while (!(fl == mvf + 1 && x == 5)) run(1, "R10 approach");
    set_cfg(2, 1, 5, 3, 1, 4, 2, 3);
    run(600, "R10 timing change at field boundary");
  endtask

  initial begin
    t_reset();
    t_full_display();
    t_disp_off();
    t_vram();
    t_refr_off();
    t_cfg_change();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule